// File: doc/BRIEF.md
# Test-Access Identification and Bypass Data Path

This block provides the two simplest test data registers of a boundary-scan test access port: a 32-bit identification register and a single-stage bypass register. It also retimes the serial output onto the falling edge of the test clock. A TAP controller and instruction decoder sit outside the block. They supply the capture and shift strobes and a one-bit select, and this block does the rest. That is, it loads the selected register, shifts it toward the serial output, and presents the least significant bit on the falling edge.

The identification word is built from three parameters. A four-bit version sits in the top nibble, a sixteen-bit part number in the middle, and a twelve-bit maker code at the bottom. The lowest bit is always forced to one. The bypass register always captures zero. Because of this, the first bit scanned out after the test logic resets tells the board tester whether an identification register is present. Neither register drives anything outside the test path, so system logic is never affected.

Top module: `jtag_idbyp_path`

## Requirements
- R1: While `trst_n` is low, the identification register holds the identification word, the bypass register holds 0, and `tdo` and `tdo_en` are 0.
- R2: The identification word is `{VERSION[3:0], PART_NUM[15:0], MFG_ID[11:1], 1'b1}`. Bit 0 is 1 even when `MFG_ID[0]` is 0. A rising `tck` edge with `capture_dr`=1 and `sel_id`=1 loads this word.
- R3: A rising `tck` edge with `shift_dr`=1 and `sel_id`=1 shifts the identification register right by one. `tdi` enters bit 31 and bit 0 leaves first, so a scan shows the word LSB first and then `tdi` delayed by 32 shifts.
- R4: A rising `tck` edge with `capture_dr`=1 and `sel_id`=0 loads 0 into the bypass register.
- R5: A rising `tck` edge with `shift_dr`=1 and `sel_id`=0 loads `tdi` into the bypass register, which gives a path of exactly one stage.
- R6: `serial_out` is bit 0 of the identification register when `sel_id`=1, and the bypass bit when `sel_id`=0.
- R7: On each falling `tck` edge, `tdo_en` takes the value of `shift_dr`. At the same edge, `tdo` takes `serial_out` if `shift_dr`=1 and 0 otherwise.
- R8: The register that is not selected, and either register when neither strobe is high, keeps its contents across rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe for the data register path |
| shift_dr | input | 1 | Shift strobe for the data register path |
| sel_id | input | 1 | 1 selects the identification register, 0 selects bypass |
| serial_out | output | 1 | LSB of the selected register, before retiming |
| tdo | output | 1 | Serial output, updated on the falling edge of `tck` |
| tdo_en | output | 1 | Output driver enable, high only while shifting |

## Verification
The bench makes a full 64-shift scan of the identification register with an irregular data pattern. A wrong shift direction, or `tdi` entering at the wrong end, would scramble either the word or the trailing pattern. The default maker code is even, so a design that took bit 0 from the parameter would show 0 as the first bit out. The bench checks the bypass path for both a captured leading zero and an exact one-stage delay. It switches registers without capturing, which catches a shift that leaks into the register that is not selected. After a second reset it scans with no capture, to confirm that reset alone restores the word.

// File: rtl/jtag_idbyp_path.sv
module jtag_idbyp_path #(
  parameter logic [3:0]  VERSION  = 4'h3,
  parameter logic [15:0] PART_NUM = 16'h5A81,
  parameter logic [11:0] MFG_ID   = 12'h0AE
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic sel_id,
  output logic serial_out,
  output logic tdo,
  output logic tdo_en
);
  localparam int IdW = 32;
  localparam logic [IdW-1:0] IdWord = {VERSION, PART_NUM, MFG_ID[11:1], 1'b1};

  logic [IdW-1:0] id_sr;
  logic           byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= IdWord;
    end else if (sel_id) begin
      if (capture_dr)    id_sr <= IdWord;
      else if (shift_dr) id_sr <= {tdi, id_sr[IdW-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (!sel_id) begin
      if (capture_dr)    byp_q <= 1'b0;
      else if (shift_dr) byp_q <= tdi;
    end
  end

  assign serial_out = sel_id ? id_sr[0] : byp_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= shift_dr & serial_out;
      tdo_en <= shift_dr;
    end
  end
endmodule

// File: rtl/jtag_idbyp_path_chk.sv
module jtag_idbyp_path_chk (
  input logic tck,
  input logic trst_n,
  input logic tdi,
  input logic capture_dr,
  input logic shift_dr,
  input logic sel_id,
  input logic serial_out,
  input logic tdo,
  input logic tdo_en
);
  a_r2_id_lsb_one: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_id) |=> (!sel_id || serial_out));

  a_r4_byp_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && !sel_id) |=> (sel_id || !serial_out));

  a_r5_byp_one_stage: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr && !sel_id) |=> (sel_id || serial_out == $past(tdi)));

  a_r8_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr) |=> (sel_id != $past(sel_id) || $stable(serial_out)));

  a_r7_en_follows: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == shift_dr);

  a_r7_idle_low: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);
endmodule

bind jtag_idbyp_path jtag_idbyp_path_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .sel_id(sel_id), .serial_out(serial_out),
  .tdo(tdo), .tdo_en(tdo_en)
);

// File: tb/jtag_idbyp_path_tb_top.sv
`timescale 1ns/1ps
module jtag_idbyp_path_tb_top;
  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'h5A81;
  localparam logic [11:0] MFG  = 12'h0AE;
  localparam logic [31:0] EXP_ID = {VER, PART, MFG[11:1], 1'b1};
  localparam logic [63:0] PAT = 64'hC3A5_19F0_7E24_B6D1;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, sel_id = 1'b1;
  logic serial_out, tdo, tdo_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  jtag_idbyp_path #(.VERSION(VER), .PART_NUM(PART), .MFG_ID(MFG)) dut_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .sel_id(sel_id), .serial_out(serial_out),
    .tdo(tdo), .tdo_en(tdo_en));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic cap, input logic sh);
    @(posedge tck); #1;
    tdi = d; capture_dr = cap; shift_dr = sh;
    #3;
  endtask

  task automatic do_reset();
    @(posedge tck); #1;
    trst_n = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
    #2;
    chk("R1 tdo", tdo, 1'b0);
    chk("R1 tdo_en", tdo_en, 1'b0);
    sel_id = 1'b0; #0.5;
    chk("R1 bypass zero", serial_out, 1'b0);
    sel_id = 1'b1; #0.5;
    chk("R1 id lsb", serial_out, 1'b1);
    @(posedge tck); #1;
    trst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R2 R3: capture then 64 shifts
    sel_id = 1'b1;
    step(1'b0, 1'b1, 1'b0);
    chk("R7 idle en", tdo_en, 1'b0);
    chk("R2 captured lsb", serial_out, 1'b1);
    for (int i = 0; i < 64; i++) begin
      step(PAT[i], 1'b0, 1'b1);
      chk("R7 shift en", tdo_en, 1'b1);
      if (i < 32) chk("R2 R3 id bit", tdo, EXP_ID[i]);
      else        chk("R3 tdi delay 32", tdo, PAT[i-32]);
      chk("R6 serial_out", serial_out, (i < 32) ? EXP_ID[i] : PAT[i-32]);
    end
    step(1'b1, 1'b0, 1'b0);
    chk("R7 idle tdo", tdo, 1'b0);
    chk("R7 idle en", tdo_en, 1'b0);
    // R4 R5: bypass
    sel_id = 1'b0;
    step(1'b1, 1'b1, 1'b0);
    chk("R4 capture zero", serial_out, 1'b0);
    for (int i = 0; i < 40; i++) begin
      step(PAT[i], 1'b0, 1'b1);
      chk("R5 one stage", tdo, (i == 0) ? 1'b0 : PAT[i-1]);
    end
    step(1'b0, 1'b0, 1'b0);
    chk("R8 bypass hold", serial_out, PAT[39]);
    step(1'b1, 1'b0, 1'b0);
    chk("R8 bypass hold", serial_out, PAT[39]);
    // R8: id register untouched by bypass scan
    sel_id = 1'b1;
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b0, 1'b1);
      chk("R8 id kept", tdo, PAT[32+i]);
    end
    // R1: reset restores word without capture
    do_reset();
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 1'b0, 1'b1);
      chk("R1 R3 reset word", tdo, EXP_ID[i]);
    end
    step(1'b0, 1'b0, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule